// File: doc/BRIEF.md
# Sector Protection Retry Engine

This block sits on the host side of a byte-wide flash device. It runs the pulse-and-verify loop that locks one sector against program and erase, or that unlocks the whole device. To lock a sector, it places the sector number on the upper address lines and raises the protect-mode control levels. It then holds the write strobe low for a timed pulse and reads back a status byte from the sector. A sector that is locked answers `01h`. When the readback does not match, the engine applies another pulse. It gives up once its pulse counter reaches a limit.

A whole-device unlock starts by locking every sector in ascending order, each one with its own fresh pulse counter. It then applies longer pulses with address line 6 high. After each such pulse it walks the sectors from 0 upward and expects `00h` from each. On a mismatch it applies another long pulse and resumes the walk at the sector that failed. When the supply for the elevated level is absent, the run opens with an unlock command write and keeps the elevated-level flags low. Every run closes with a `F0h` command write, which returns the device to reading, and then a one-cycle done strobe with a pass flag. The elevated voltages appear only as logic flags. All durations are counted in clock cycles and set by parameters.

Top module: `flprot_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted during a run, the outputs are idle: chip enable, output enable and write strobe are all high (inactive). The elevated-level flags, A6, `busy`, `done` and the data drive enable are all low.
- R2: A lock pulse holds chip enable and the write strobe low, output enable high and A6 low, for exactly PULSE_P cycles. Both elevated-level flags equal the `use_hv` value latched at start. The data bus is not driven.
- R3: The verify read that follows each pulse drives chip enable and output enable low and the write strobe high. It keeps A6 low and the output-enable elevated flag low. The A9 elevated flag equals the latched `use_hv`. A locked sector is recognised by the readback code `01h`.
- R4: The pulse counter is 1 at the first pulse for each sector. Each failed verify increments it and applies another pulse. A failed verify that brings the count to MAX_PULSE ends the run with `pass`=0, so one sector or phase receives at most MAX_PULSE-1 pulses.
- R5: A whole-device unlock (`unprot_op`=1) first locks sectors 0 to N_SECT-1 in ascending order, each with its own counter. No unlock pulse is applied before every sector reads `01h`. If a sector cannot be locked, the run fails with no unlock pulse applied.
- R6: An unlock pulse holds A6 high for exactly PULSE_U cycles. Afterwards, sectors are read in ascending order and each must return `00h`. A mismatch triggers another unlock pulse under a single shared counter, and verification resumes at the failing sector.
- R7: When `use_hv`=0 at start, exactly one command write carrying UNLOCK_CODE precedes the first pulse. Both elevated-level flags stay low for the whole run. When `use_hv`=1, no such write occurs.
- R8: Every run, whether it passes or fails, ends with one command write of `F0h`, lasting WR_CYC cycles. The engine then raises `done` for exactly one cycle with the result on `pass`, and `busy` falls on the next cycle.
- R9: `start` and the selection inputs are ignored while `busy` is high.
- R10: `fl_sect` (the device's top three address lines, A18..A16) and `sector_idx` carry the sector being worked on. For a single-sector lock this is `sector_sel` as captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| unprot_op | input | 1 | 0: lock one sector, 1: unlock whole device |
| sector_sel | input | SEC_W | Sector to lock |
| use_hv | input | 1 | 1: elevated-level supply present |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result of the last run |
| sector_idx | output | SEC_W | Current sector |
| fl_ce_n | output | 1 | Device chip enable, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| fl_we_n | output | 1 | Device write strobe, active low |
| fl_oe_hv | output | 1 | Output-enable pin at elevated level |
| fl_a9_hv | output | 1 | A9 pin at elevated level |
| fl_a6 | output | 1 | A6 level (1 during unlock pulses) |
| fl_sect | output | SEC_W | Device sector address lines |
| fl_dq_out | output | 8 | Command data to device |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_dq_in | input | 8 | Readback data from device |

## Verification
The bench targets the limits of the retry counter. A sector that needs MAX_PULSE-1 pulses must pass; a counter that is off by one would fail it, or would apply one pulse too many to a sector needing MAX_PULSE. In the whole-device flow, the bench checks that no unlock pulse arrives while any sector is still unlocked, that sectors are locked in ascending order, and that a failure during the lock phase ends the run with no unlock pulse. It also confirms that the unlock command appears only without the elevated supply, that `F0h` closes failed runs as well as passing ones, and that a second `start` during a run cannot change the sector being worked on.

// File: rtl/flprot_pkg.sv
package flprot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK,
        ST_PULSE,
        ST_VERIFY,
        ST_RSTCMD,
        ST_DONE
    } flp_state_e;

    function automatic int max4(input int a, input int b, input int c, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/flprot_timer.sv
module flprot_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len - W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

    // R2
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len > W'(1)) |=> !last);

endmodule

// File: rtl/flprot_pins.sv
module flprot_pins
    import flprot_pkg::*;
#(
    parameter logic [7:0] UNLOCK_CODE = 8'h60
) (
    input  flp_state_e st,
    input  logic       hv,
    input  logic       unp_ph,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       oe_hv,
    output logic       a9_hv,
    output logic       a6,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    localparam logic [7:0] CMD_READ = 8'hF0;

    always_comb begin
        ce_n   = 1'b1;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        oe_hv  = 1'b0;
        a9_hv  = 1'b0;
        a6     = 1'b0;
        dq_out = 8'h00;
        dq_oe  = 1'b0;
        case (st)
            ST_UNLOCK: begin
                ce_n   = 1'b0;
                we_n   = 1'b0;
                dq_oe  = 1'b1;
                dq_out = UNLOCK_CODE;
            end
            ST_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                oe_hv = hv;
                a9_hv = hv;
                a6    = unp_ph;
            end
            ST_VERIFY: begin
                ce_n  = 1'b0;
                oe_n  = 1'b0;
                a9_hv = hv;
            end
            ST_RSTCMD: begin
                ce_n   = 1'b0;
                we_n   = 1'b0;
                dq_oe  = 1'b1;
                dq_out = CMD_READ;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flprot_ctrl.sv
module flprot_ctrl
    import flprot_pkg::*;
#(
    parameter int         N_SECT      = 8,
    parameter int         PULSE_P     = 1000,
    parameter int         PULSE_U     = 1200000,
    parameter int         WR_CYC      = 4,
    parameter int         RD_CYC      = 4,
    parameter int         MAX_PULSE   = 32,
    parameter logic [7:0] UNLOCK_CODE = 8'h60,
    localparam int        SEC_W       = $clog2(N_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             unprot_op,
    input  logic [SEC_W-1:0] sector_sel,
    input  logic             use_hv,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [SEC_W-1:0] sector_idx,
    output logic             fl_ce_n,
    output logic             fl_oe_n,
    output logic             fl_we_n,
    output logic             fl_oe_hv,
    output logic             fl_a9_hv,
    output logic             fl_a6,
    output logic [SEC_W-1:0] fl_sect,
    output logic [7:0]       fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [7:0]       fl_dq_in
);
    localparam int TW    = $clog2(max4(PULSE_P, PULSE_U, WR_CYC, RD_CYC) + 1);
    localparam int CNT_W = $clog2(MAX_PULSE + 1);

    localparam logic [TW-1:0]    LEN_P    = TW'(PULSE_P);
    localparam logic [TW-1:0]    LEN_U    = TW'(PULSE_U);
    localparam logic [TW-1:0]    LEN_W    = TW'(WR_CYC);
    localparam logic [TW-1:0]    LEN_R    = TW'(RD_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_PULSE - 1);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(N_SECT - 1);
    localparam logic [7:0]       CODE_LOCKED = 8'h01;
    localparam logic [7:0]       CODE_OPEN   = 8'h00;

    typedef struct packed {
        flp_state_e       st;
        logic             unp_op;
        logic             hv;
        logic             unp_ph;
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
        logic             pass;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, unp_op: 1'b0, hv: 1'b0, unp_ph: 1'b0,
                                 sec: '0, cnt: '0, pass: 1'b0};

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load, tmr_last;
    logic [TW-1:0] tmr_len;
    logic [7:0]    exp_code;
    logic          code_ok, sec_last;

    flprot_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_len  = LEN_W;
        exp_code = ctl_q.unp_ph ? CODE_OPEN : CODE_LOCKED;
        code_ok  = (fl_dq_in == exp_code);
        sec_last = (ctl_q.sec == SEC_LAST);
        case (ctl_q.st)
            ST_IDLE: if (start) begin
                ctl_d.unp_op = unprot_op;
                ctl_d.hv     = use_hv;
                ctl_d.unp_ph = 1'b0;
                ctl_d.sec    = unprot_op ? '0 : sector_sel;
                ctl_d.cnt    = CNT_W'(1);
                ctl_d.pass   = 1'b0;
                tmr_load     = 1'b1;
                if (use_hv) begin
                    ctl_d.st = ST_PULSE;
                    tmr_len  = LEN_P;
                end else begin
                    ctl_d.st = ST_UNLOCK;
                    tmr_len  = LEN_W;
                end
            end
            ST_UNLOCK: if (tmr_last) begin
                ctl_d.st = ST_PULSE;
                tmr_load = 1'b1;
                tmr_len  = LEN_P;
            end
            ST_PULSE: if (tmr_last) begin
                ctl_d.st = ST_VERIFY;
                tmr_load = 1'b1;
                tmr_len  = LEN_R;
            end
            ST_VERIFY: if (tmr_last) begin
                tmr_load = 1'b1;
                if (code_ok) begin
                    if (ctl_q.unp_ph && !sec_last) begin
                        ctl_d.sec = ctl_q.sec + SEC_W'(1);
                        tmr_len   = LEN_R;
                    end else if (!ctl_q.unp_ph && ctl_q.unp_op && !sec_last) begin
                        ctl_d.st  = ST_PULSE;
                        ctl_d.sec = ctl_q.sec + SEC_W'(1);
                        ctl_d.cnt = CNT_W'(1);
                        tmr_len   = LEN_P;
                    end else if (!ctl_q.unp_ph && ctl_q.unp_op) begin
                        ctl_d.st     = ST_PULSE;
                        ctl_d.unp_ph = 1'b1;
                        ctl_d.sec    = '0;
                        ctl_d.cnt    = CNT_W'(1);
                        tmr_len      = LEN_U;
                    end else begin
                        ctl_d.st   = ST_RSTCMD;
                        ctl_d.pass = 1'b1;
                        tmr_len    = LEN_W;
                    end
                end else if (ctl_q.cnt == CNT_LAST) begin
                    ctl_d.st   = ST_RSTCMD;
                    ctl_d.pass = 1'b0;
                    tmr_len    = LEN_W;
                end else begin
                    ctl_d.st  = ST_PULSE;
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    tmr_len   = ctl_q.unp_ph ? LEN_U : LEN_P;
                end
            end
            ST_RSTCMD: if (tmr_last) ctl_d.st = ST_DONE;
            ST_DONE:   ctl_d.st = ST_IDLE;
            default:   ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    flprot_pins #(.UNLOCK_CODE(UNLOCK_CODE)) u_pins (
        .st    (ctl_q.st),
        .hv    (ctl_q.hv),
        .unp_ph(ctl_q.unp_ph),
        .ce_n  (fl_ce_n),
        .oe_n  (fl_oe_n),
        .we_n  (fl_we_n),
        .oe_hv (fl_oe_hv),
        .a9_hv (fl_a9_hv),
        .a6    (fl_a6),
        .dq_out(fl_dq_out),
        .dq_oe (fl_dq_oe)
    );

    assign busy       = (ctl_q.st != ST_IDLE);
    assign done       = (ctl_q.st == ST_DONE);
    assign pass       = ctl_q.pass;
    assign sector_idx = ctl_q.sec;
    assign fl_sect    = ctl_q.sec;

    // R2
    pulse_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !fl_dq_oe) |-> (!fl_ce_n && fl_oe_n && fl_oe_hv == ctl_q.hv
                                     && fl_a9_hv == ctl_q.hv));
    // R3
    verify_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n && !fl_a6 && !fl_oe_hv));
    // R4
    pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.cnt != '0 && int'(ctl_q.cnt) < MAX_PULSE));
    // R6
    unlock_a6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_a6 |-> (ctl_q.unp_op && !fl_we_n));
    // R7
    no_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_q.hv) |-> (!fl_a9_hv && !fl_oe_hv));
    // R8
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R9
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctl_q.unp_op) && $stable(ctl_q.hv)));

endmodule

// File: tb/flprot_ctrl_test.sv
`timescale 1ns/1ps
module flprot_ctrl_test;
    localparam int NS   = 8;
    localparam int SW   = 3;
    localparam int PP   = 5;
    localparam int PU   = 9;
    localparam int WR   = 2;
    localparam int RD   = 3;
    localparam int MAXP = 32;
    localparam logic [7:0] UNL = 8'h60;

    typedef struct packed {
        int op; int sec; int hv; int np; int nu; int pass; int pp; int up;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{0, 3, 1,  1,  0, 1,  1,  0},
        '{0, 5, 0,  4,  0, 1,  4,  0},
        '{0, 0, 1, 31,  0, 1, 31,  0},
        '{0, 7, 1, 32,  0, 0, 31,  0},
        '{1, 0, 1,  2,  3, 1, 16,  3},
        '{1, 0, 0,  1,  1, 1,  8,  1},
        '{1, 0, 1,  1, 40, 0,  8, 31},
        '{1, 0, 1, 32,  1, 0, 31,  0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, unprot_op = 1'b0, use_hv = 1'b0;
    logic [SW-1:0] sector_sel = '0;
    logic busy, done, pass;
    logic [SW-1:0] sector_idx, fl_sect;
    logic fl_ce_n, fl_oe_n, fl_we_n, fl_oe_hv, fl_a9_hv, fl_a6, fl_dq_oe;
    logic [7:0] fl_dq_out, fl_dq_in;

    always #2 clk = ~clk;

    flprot_ctrl #(.N_SECT(NS), .PULSE_P(PP), .PULSE_U(PU), .WR_CYC(WR), .RD_CYC(RD),
                  .MAX_PULSE(MAXP), .UNLOCK_CODE(UNL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .unprot_op(unprot_op),
        .sector_sel(sector_sel), .use_hv(use_hv), .busy(busy), .done(done),
        .pass(pass), .sector_idx(sector_idx), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_oe_hv(fl_oe_hv), .fl_a9_hv(fl_a9_hv), .fl_a6(fl_a6),
        .fl_sect(fl_sect), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    // device model
    logic mdl_clr = 1'b1;
    int   cur_np = 0, cur_nu = 0, cur_hv = 1;
    logic [NS-1:0] prot;
    int need_l [NS];
    int need_u, pp_cnt, up_cnt, pin_err, width_err, order_err, viol_err;
    int unlock_cnt, unlock_late, f0_cnt, pul_w, last_psec;
    logic [7:0] last_cmd, data_prev;
    logic pul_prev, cmd_prev, a6_prev;
    logic [SW-1:0] sec_prev;

    assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? (prot[fl_sect] ? 8'h01 : 8'h00) : 8'hFF;

    always @(negedge clk) begin
        if (mdl_clr) begin
            prot = '0;
            for (int s = 0; s < NS; s++) need_l[s] = cur_np;
            need_u = cur_nu; pp_cnt = 0; up_cnt = 0; pin_err = 0; width_err = 0;
            order_err = 0; viol_err = 0; unlock_cnt = 0; unlock_late = 0; f0_cnt = 0;
            pul_w = 0; last_psec = 0; last_cmd = 8'h00; data_prev = 8'h00;
            pul_prev = 1'b0; cmd_prev = 1'b0; a6_prev = 1'b0; sec_prev = '0;
        end else begin
            logic pul_now, cmd_now;
            pul_now = !fl_we_n && !fl_dq_oe;
            cmd_now = !fl_we_n && fl_dq_oe;
            if (pul_now) begin
                if (fl_ce_n || !fl_oe_n || fl_oe_hv != cur_hv[0] || fl_a9_hv != cur_hv[0])
                    pin_err++;
                pul_w++;
            end else if (!fl_oe_n) begin
                if (!fl_we_n || fl_ce_n || fl_a6 || fl_oe_hv || fl_a9_hv != cur_hv[0])
                    pin_err++;
            end
            if (pul_prev && !pul_now) begin
                if (pul_w != (a6_prev ? PU : PP)) width_err++;
                if (a6_prev) begin
                    up_cnt++;
                    if (prot != '1) viol_err++;
                    if (need_u > 0) begin
                        need_u--;
                        if (need_u == 0) prot = '0;
                    end
                end else begin
                    pp_cnt++;
                    if (int'(sec_prev) < last_psec) order_err++;
                    last_psec = int'(sec_prev);
                    if (need_l[sec_prev] > 0) begin
                        need_l[sec_prev]--;
                        if (need_l[sec_prev] == 0) prot[sec_prev] = 1'b1;
                    end
                end
                pul_w = 0;
            end
            if (cmd_prev && !cmd_now) begin
                last_cmd = data_prev;
                if (data_prev == 8'hF0) f0_cnt++;
                if (data_prev == UNL) begin
                    unlock_cnt++;
                    if (pp_cnt + up_cnt != 0) unlock_late++;
                end
            end
            pul_prev = pul_now; cmd_prev = cmd_now; a6_prev = fl_a6;
            sec_prev = fl_sect; data_prev = fl_dq_out;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input int op, input int sec, input int hv, input int np,
                       input int nu, output logic got_pass);
        @(posedge clk);
        cur_np = np; cur_nu = nu; cur_hv = hv; mdl_clr = 1'b1;
        @(posedge clk);
        mdl_clr = 1'b0;
        @(negedge clk);
        unprot_op = op[0]; sector_sel = SW'(sec); use_hv = hv[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        check(done, "R8 done timeout", int'(done), 1);
        got_pass = pass;
        @(negedge clk);
        check(!done && !busy, "R8 done one cycle", int'(done), 0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic p;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !fl_a9_hv && !fl_oe_hv && !fl_a6,
              "R1 pins in reset", 0, 1);
        check(!busy && !done, "R1 busy/done in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && fl_ce_n, "R1 idle after reset", int'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            string tp;
            tp = (VEC[v].op == 1) ? "R6" : "R4";
            run(VEC[v].op, VEC[v].sec, VEC[v].hv, VEC[v].np, VEC[v].nu, p);
            check(int'(p) == VEC[v].pass, {tp, " pass flag"}, int'(p), VEC[v].pass);
            check(pp_cnt == VEC[v].pp, (VEC[v].op == 1) ? "R5 lock pulses" : "R4 lock pulses",
                  pp_cnt, VEC[v].pp);
            check(up_cnt == VEC[v].up, "R6 unlock pulses", up_cnt, VEC[v].up);
            check(width_err == 0, "R2 pulse width", width_err, 0);
            check(pin_err == 0, "R3 pin levels", pin_err, 0);
            check(viol_err == 0 && order_err == 0, "R5 order", viol_err + order_err, 0);
            check(unlock_cnt == (VEC[v].hv ? 0 : 1) && unlock_late == 0, "R7 unlock write",
                  unlock_cnt, VEC[v].hv ? 0 : 1);
            check(f0_cnt == 1 && last_cmd == 8'hF0, "R8 read command", int'(last_cmd), 'hF0);
            if (VEC[v].op == 0)
                check(int'(sector_idx) == VEC[v].sec, "R10 sector index", int'(sector_idx),
                      VEC[v].sec);
        end

        // R9: start while busy is ignored
        fork
            run(0, 2, 1, 3, 0, p);
            begin
                repeat (10) @(negedge clk);
                unprot_op = 1'b1; sector_sel = 3'd6; use_hv = 1'b0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(p == 1'b1 && pp_cnt == 3, "R9 lock count unchanged", pp_cnt, 3);
        check(up_cnt == 0 && unlock_cnt == 0, "R9 no op switch", up_cnt + unlock_cnt, 0);
        check(int'(sector_idx) == 2, "R9 R10 sector kept", int'(sector_idx), 2);

        // R1: reset in the middle of a pulse
        @(posedge clk);
        mdl_clr = 1'b1;
        @(negedge clk);
        unprot_op = 1'b0; sector_sel = 3'd1; use_hv = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!fl_we_n && fl_a9_hv, "R2 pulse underway", int'(fl_we_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(fl_we_n && fl_ce_n && !fl_a9_hv && !fl_oe_hv && !busy, "R1 mid-run reset",
              int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && fl_we_n, "R1 stays idle", int'(busy), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule